// File: doc/BRIEF.md
# Packed Lane Pair, Zip and Unzip Permuter

This block rearranges the sub-elements of two packed SIMD source operands into one result. A five-bit operation code picks one of four families: pairing, where each result lane is built from one sub-element of each source (chosen independently as the even or odd half of that source lane) at byte, halfword or word granularity; zipping, where bytes or halfwords from the low or upper half of both sources are interleaved; unzipping, where the even- or odd-indexed bytes or halfwords of each source are gathered into one half of the result; and lane sign extension.

The datapath is a single combinational crossbar whose result and illegal flag are captured in one output register, so a result appears on the clock edge after its operands and operation code are presented. The operand width `XLEN` is 32 or 64. Operations that only make sense on 64-bit operands, and unassigned operation codes, raise the illegal flag and produce a zero result.

Top module: `pperm_top`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_o` and `illegal_o` become zero whatever the other inputs are; otherwise `rd_o` and `illegal_o` reflect the `op_i`, `rs1_i`, `rs2_i` sampled at the previous rising edge (one cycle of latency).
- R2: Byte pairing, codes 0 to 3: in each 16-bit result lane, bits [7:0] come from `rs1_i` and bits [15:8] from `rs2_i` of the same lane; code bit 1 set takes the upper byte of the `rs1_i` lane instead of its lower byte, code bit 0 set takes the upper byte of the `rs2_i` lane (0 = both lower, 1 = rs1 lower/rs2 upper, 2 = rs1 upper/rs2 lower, 3 = both upper).
- R3: Halfword pairing, codes 4 to 7: the same four selections as R2 (code minus 4) applied to 16-bit halves of each 32-bit lane.
- R4: Word pairing, codes 8, 9, 10: result bits [31:0] come from a word of `rs1_i` and bits [63:32] from a word of `rs2_i`; code 8 takes rs1 word 0 and rs2 word 1, code 9 takes rs1 word 1 and rs2 word 0, code 10 takes word 1 of both.
- R5: Byte zip, code 11 (low) and 12 (high): result byte 2k is byte k+B of `rs1_i` and byte 2k+1 is byte k+B of `rs2_i`, k = 0..3, with B = 0 for code 11 and B = 4 for code 12.
- R6: Byte unzip, code 13 (even) and 14 (odd): result byte k is byte 2k+P of `rs1_i` and result byte 4+k is byte 2k+P of `rs2_i`, k = 0..3, with P = 0 for code 13 and 1 for code 14.
- R7: Halfword zip, code 15 (low) and 16 (high): result halfword 2k is halfword k+B of `rs1_i` and halfword 2k+1 is halfword k+B of `rs2_i`, k = 0..1, with B = 0 or 2.
- R8: Halfword unzip, code 17 (even) and 18 (odd): result halfword k is halfword 2k+P of `rs1_i` and halfword 2+k is halfword 2k+P of `rs2_i`, k = 0..1, with P = 0 or 1.
- R9: Code 19 replaces every 16-bit lane of `rs1_i` with the sign extension of its lower byte.
- R10: Code 20 gives two 32-bit words holding the sign-extended bytes 0 and 4 of `rs1_i`; code 21 gives two words holding the sign-extended halfwords 0 and 2.
- R11: Codes 22 to 31 set `illegal_o` and give a zero `rd_o`; codes 0 to 7 and 19 never set `illegal_o`.
- R12: With `XLEN` = 32, codes 8 to 18, 20 and 21 set `illegal_o` and give a zero `rd_o`; with `XLEN` = 64 they are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand |
| rd_o | output | XLEN | Registered permuted result |
| illegal_o | output | 1 | Registered flag: operation code not supported at this width |

## Verification
On every cycle the assertions check that a flagged result is zero, that unassigned codes are flagged and always-legal codes are not, and spot lanes of the byte pair, byte zip, byte unzip, word pair and byte sign-extension results against the operands of the previous cycle, plus the width-dependent flagging at 32 bits. The full lane orderings of every code, both halves and both parities, the halfword families, reset taking priority over a pending operation, and the agreement between the 32-bit and 64-bit builds come only from the bench's scenarios, which run every code against several operand patterns on both widths.

// File: rtl/pperm_pkg.sv
package pperm_pkg;

    typedef enum logic [4:0] {
        OP_PAIR_B_LL   = 5'd0,
        OP_PAIR_B_LH   = 5'd1,
        OP_PAIR_B_HL   = 5'd2,
        OP_PAIR_B_HH   = 5'd3,
        OP_PAIR_H_LL   = 5'd4,
        OP_PAIR_H_LH   = 5'd5,
        OP_PAIR_H_HL   = 5'd6,
        OP_PAIR_H_HH   = 5'd7,
        OP_PAIR_W_LH   = 5'd8,
        OP_PAIR_W_HL   = 5'd9,
        OP_PAIR_W_HH   = 5'd10,
        OP_ZIP8_LO     = 5'd11,
        OP_ZIP8_HI     = 5'd12,
        OP_UNZIP8_EV   = 5'd13,
        OP_UNZIP8_OD   = 5'd14,
        OP_ZIP16_LO    = 5'd15,
        OP_ZIP16_HI    = 5'd16,
        OP_UNZIP16_EV  = 5'd17,
        OP_UNZIP16_OD  = 5'd18,
        OP_SEXT_B2H    = 5'd19,
        OP_SEXT_B2W    = 5'd20,
        OP_SEXT_H2W    = 5'd21
    } perm_op_e;

    localparam int unsigned NUM_OPS = 22;

    // Per-source choice of the lower or upper half of a lane.
    typedef struct packed {
        logic src1_upper;
        logic src2_upper;
    } pair_sel_t;

    function automatic logic code_defined(logic [4:0] code);
        return code < 5'(NUM_OPS);
    endfunction

    function automatic logic needs_wide(logic [4:0] code);
        return (code >= 5'(OP_PAIR_W_LH) && code <= 5'(OP_UNZIP16_OD)) ||
               code == 5'(OP_SEXT_B2W) || code == 5'(OP_SEXT_H2W);
    endfunction

    // Narrow pairing codes encode the selection in their two low bits;
    // word pairing starts at the second selection.
    function automatic pair_sel_t narrow_sel(logic [4:0] code);
        pair_sel_t s;
        s.src1_upper = code[1];
        s.src2_upper = code[0];
        return s;
    endfunction

    function automatic pair_sel_t word_sel(logic [4:0] code);
        logic [1:0] m;
        pair_sel_t  s;
        m = 2'(code - 5'd7);
        s.src1_upper = m[1];
        s.src2_upper = m[0];
        return s;
    endfunction

endpackage

// File: rtl/pperm_pair.sv
module pperm_pair
    import pperm_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned LANE_W = 16
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  pair_sel_t       sel_i,
    output logic [XLEN-1:0] y_o
);
    localparam int unsigned HALF_W = LANE_W / 2;
    localparam int unsigned LANES  = XLEN / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
        assign a_lo = a_i[g*LANE_W +: HALF_W];
        assign a_hi = a_i[g*LANE_W + HALF_W +: HALF_W];
        assign b_lo = b_i[g*LANE_W +: HALF_W];
        assign b_hi = b_i[g*LANE_W + HALF_W +: HALF_W];
        assign y_o[g*LANE_W +: HALF_W]          = sel_i.src1_upper ? a_hi : a_lo;
        assign y_o[g*LANE_W + HALF_W +: HALF_W] = sel_i.src2_upper ? b_hi : b_lo;
    end

endmodule

// File: rtl/pperm_zip.sv
module pperm_zip #(
    parameter int unsigned ELEM_W = 8
) (
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    input  logic        upper_i,
    output logic [63:0] zip_o,
    output logic [63:0] unzip_o
);
    localparam int unsigned PER_HALF = 32 / ELEM_W;

    for (genvar k = 0; k < PER_HALF; k++) begin : g_elem
        logic [ELEM_W-1:0] za, zb, ua, ub;
        // Interleave: element k of the chosen half of each source.
        assign za = upper_i ? a_i[(k + PER_HALF)*ELEM_W +: ELEM_W] : a_i[k*ELEM_W +: ELEM_W];
        assign zb = upper_i ? b_i[(k + PER_HALF)*ELEM_W +: ELEM_W] : b_i[k*ELEM_W +: ELEM_W];
        assign zip_o[(2*k)*ELEM_W +: ELEM_W]     = za;
        assign zip_o[(2*k + 1)*ELEM_W +: ELEM_W] = zb;
        // Gather: element 2k or 2k+1 of each source.
        assign ua = upper_i ? a_i[(2*k + 1)*ELEM_W +: ELEM_W] : a_i[(2*k)*ELEM_W +: ELEM_W];
        assign ub = upper_i ? b_i[(2*k + 1)*ELEM_W +: ELEM_W] : b_i[(2*k)*ELEM_W +: ELEM_W];
        assign unzip_o[k*ELEM_W +: ELEM_W]            = ua;
        assign unzip_o[32 + k*ELEM_W +: ELEM_W]       = ub;
    end

endmodule

// File: rtl/pperm_sext.sv
module pperm_sext #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    output logic [XLEN-1:0] b2h_o,
    output logic [XLEN-1:0] b2w_o,
    output logic [XLEN-1:0] h2w_o
);
    localparam int unsigned HWORDS = XLEN / 16;
    localparam int unsigned WORDS  = XLEN / 32;

    for (genvar h = 0; h < HWORDS; h++) begin : g_h
        assign b2h_o[h*16 +: 16] = {{8{a_i[h*16 + 7]}}, a_i[h*16 +: 8]};
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_w
        assign b2w_o[w*32 +: 32] = {{24{a_i[w*32 + 7]}},  a_i[w*32 +: 8]};
        assign h2w_o[w*32 +: 32] = {{16{a_i[w*32 + 15]}}, a_i[w*32 +: 16]};
    end

endmodule

// File: rtl/pperm_top.sv
module pperm_top
    import pperm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      op_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    output logic [XLEN-1:0] rd_o,
    output logic            illegal_o
);
    localparam logic WIDE = (XLEN >= 64);

    perm_op_e        op_e;
    logic [XLEN-1:0] pair_b, pair_h, pair_w;
    logic [XLEN-1:0] zip8, unzip8, zip16, unzip16;
    logic [XLEN-1:0] sx_b2h, sx_b2w, sx_h2w;
    logic [XLEN-1:0] res;
    logic            bad;

    assign op_e = perm_op_e'(op_i);

    pperm_pair #(.XLEN(XLEN), .LANE_W(16)) u_pair_b (
        .a_i(rs1_i), .b_i(rs2_i), .sel_i(narrow_sel(op_i)), .y_o(pair_b)
    );

    pperm_pair #(.XLEN(XLEN), .LANE_W(32)) u_pair_h (
        .a_i(rs1_i), .b_i(rs2_i), .sel_i(narrow_sel(op_i)), .y_o(pair_h)
    );

    pperm_sext #(.XLEN(XLEN)) u_sext (
        .a_i(rs1_i), .b2h_o(sx_b2h), .b2w_o(sx_b2w), .h2w_o(sx_h2w)
    );

    if (WIDE) begin : g_wide
        logic [63:0] z8, u8, z16, u16;
        logic        up8, up16;

        assign up8  = (op_e == OP_ZIP8_HI)  || (op_e == OP_UNZIP8_OD);
        assign up16 = (op_e == OP_ZIP16_HI) || (op_e == OP_UNZIP16_OD);

        pperm_pair #(.XLEN(XLEN), .LANE_W(64)) u_pair_w (
            .a_i(rs1_i), .b_i(rs2_i), .sel_i(word_sel(op_i)), .y_o(pair_w)
        );

        pperm_zip #(.ELEM_W(8)) u_zip8 (
            .a_i(rs1_i[63:0]), .b_i(rs2_i[63:0]), .upper_i(up8),
            .zip_o(z8), .unzip_o(u8)
        );

        pperm_zip #(.ELEM_W(16)) u_zip16 (
            .a_i(rs1_i[63:0]), .b_i(rs2_i[63:0]), .upper_i(up16),
            .zip_o(z16), .unzip_o(u16)
        );

        assign zip8    = XLEN'(z8);
        assign unzip8  = XLEN'(u8);
        assign zip16   = XLEN'(z16);
        assign unzip16 = XLEN'(u16);
    end else begin : g_narrow
        assign pair_w  = '0;
        assign zip8    = '0;
        assign unzip8  = '0;
        assign zip16   = '0;
        assign unzip16 = '0;
    end

    assign bad = !code_defined(op_i) || (!WIDE && needs_wide(op_i));

    always_comb begin
        res = '0;
        unique case (op_e)
            OP_PAIR_B_LL, OP_PAIR_B_LH, OP_PAIR_B_HL, OP_PAIR_B_HH: res = pair_b;
            OP_PAIR_H_LL, OP_PAIR_H_LH, OP_PAIR_H_HL, OP_PAIR_H_HH: res = pair_h;
            OP_PAIR_W_LH, OP_PAIR_W_HL, OP_PAIR_W_HH:               res = pair_w;
            OP_ZIP8_LO, OP_ZIP8_HI:                                 res = zip8;
            OP_UNZIP8_EV, OP_UNZIP8_OD:                             res = unzip8;
            OP_ZIP16_LO, OP_ZIP16_HI:                               res = zip16;
            OP_UNZIP16_EV, OP_UNZIP16_OD:                           res = unzip16;
            OP_SEXT_B2H:                                            res = sx_b2h;
            OP_SEXT_B2W:                                            res = sx_b2w;
            OP_SEXT_H2W:                                            res = sx_h2w;
            default:                                                res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_o      <= '0;
            illegal_o <= 1'b0;
        end else begin
            rd_o      <= bad ? '0 : res;
            illegal_o <= bad;
        end
    end

endmodule

// File: rtl/pperm_chk.sv
module pperm_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      op_i,
    input logic [XLEN-1:0] rs1_i,
    input logic [XLEN-1:0] rs2_i,
    input logic [XLEN-1:0] rd_o,
    input logic            illegal_o
);
    // R11 / R12: a flagged result is always zero
    p_flag_zero_r11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> rd_o == '0);

    p_undef_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) >= 5'd22) |-> illegal_o);

    p_legal_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_i) < 5'd8 || $past(op_i) == 5'd19)) |-> !illegal_o);

    p_pair_ll_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 5'd0) |->
            (rd_o[7:0] == $past(rs1_i[7:0]) && rd_o[15:8] == $past(rs2_i[7:0])));

    p_sext_b2h_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 5'd19) |-> rd_o[15:8] == {8{$past(rs1_i[7])}});

    if (XLEN >= 64) begin : g_wide
        p_zip8_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) == 5'd11) |->
                (rd_o[15:8] == $past(rs2_i[7:0]) && rd_o[63:56] == $past(rs2_i[31:24])));

        p_unzip8_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) == 5'd14) |->
                (rd_o[7:0] == $past(rs1_i[15:8]) && rd_o[39:32] == $past(rs2_i[15:8])));

        p_pair_w_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op_i) == 5'd10) |-> rd_o[31:0] == $past(rs1_i[63:32]));
    end else begin : g_narrow
        p_wide_flag_r12: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (($past(op_i) >= 5'd8 && $past(op_i) <= 5'd18) ||
                             $past(op_i) == 5'd20 || $past(op_i) == 5'd21)) |-> illegal_o);
    end

endmodule

bind pperm_top pperm_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
    .rd_o(rd_o), .illegal_o(illegal_o)
);

// File: tb/pperm_top_tb.sv
module pperm_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op;
    logic [63:0] a, b;
    logic [63:0] rd64;
    logic        ill64;
    logic [31:0] rd32;
    logic        ill32;

    int errs   = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pperm_top #(.XLEN(64)) u_dut (
        .clk(clk), .rst(rst), .op_i(op), .rs1_i(a), .rs2_i(b),
        .rd_o(rd64), .illegal_o(ill64)
    );

    pperm_top #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst(rst), .op_i(op), .rs1_i(a[31:0]), .rs2_i(b[31:0]),
        .rd_o(rd32), .illegal_o(ill32)
    );

    // Behavioural reference: returns {illegal, result} for width xl.
    function automatic logic [64:0] model(int xl, logic [4:0] o, logic [63:0] x, logic [63:0] y);
        logic [63:0] r = '0;
        int code = int'(o);
        bit wide = (code >= 8 && code <= 18) || code == 20 || code == 21;
        if (code > 21 || (xl < 64 && wide)) return {1'b1, 64'd0};
        if (code <= 7) begin
            int lw = (code < 4) ? 16 : 32;
            int hw = lw / 2;
            for (int i = 0; i < xl / lw; i++) begin
                for (int j = 0; j < hw; j++) begin
                    r[i*lw + j]      = x[i*lw + j + (o[1] ? hw : 0)];
                    r[i*lw + hw + j] = y[i*lw + j + (o[0] ? hw : 0)];
                end
            end
        end else if (code <= 10) begin
            int w1 = (code == 8) ? 0 : 1;
            int w2 = (code == 9) ? 0 : 1;
            r = {y[w2*32 +: 32], x[w1*32 +: 32]};
        end else if (code <= 12) begin
            int base = (code == 12) ? 4 : 0;
            for (int k = 0; k < 4; k++) begin
                r[16*k +: 8]     = x[8*(k+base) +: 8];
                r[16*k + 8 +: 8] = y[8*(k+base) +: 8];
            end
        end else if (code <= 14) begin
            int p = code - 13;
            for (int k = 0; k < 4; k++) begin
                r[8*k +: 8]      = x[8*(2*k+p) +: 8];
                r[32 + 8*k +: 8] = y[8*(2*k+p) +: 8];
            end
        end else if (code <= 16) begin
            int base = (code == 16) ? 2 : 0;
            for (int k = 0; k < 2; k++) begin
                r[32*k +: 16]      = x[16*(k+base) +: 16];
                r[32*k + 16 +: 16] = y[16*(k+base) +: 16];
            end
        end else if (code <= 18) begin
            int p = code - 17;
            for (int k = 0; k < 2; k++) begin
                r[16*k +: 16]      = x[16*(2*k+p) +: 16];
                r[32 + 16*k +: 16] = y[16*(2*k+p) +: 16];
            end
        end else if (code == 19) begin
            for (int i = 0; i < xl / 16; i++) begin
                logic signed [7:0] sb = x[16*i +: 8];
                r[16*i +: 16] = 16'(sb);
            end
        end else if (code == 20) begin
            logic signed [7:0] s0 = x[7:0];
            logic signed [7:0] s1 = x[39:32];
            r = {32'(s1), 32'(s0)};
        end else begin
            logic signed [15:0] t0 = x[15:0];
            logic signed [15:0] t1 = x[47:32];
            r = {32'(t1), 32'(t0)};
        end
        if (xl < 64) r[63:32] = '0;
        return {1'b0, r};
    endfunction

    function automatic string tag_of(logic [4:0] o, bit narrow);
        int c = int'(o);
        if (c > 21) return "R11";
        if (narrow && ((c >= 8 && c <= 18) || c == 20 || c == 21)) return "R12";
        if (c <= 3)  return "R2";
        if (c <= 7)  return "R3";
        if (c <= 10) return "R4";
        if (c <= 12) return "R5";
        if (c <= 14) return "R6";
        if (c <= 16) return "R7";
        if (c <= 18) return "R8";
        if (c == 19) return "R9";
        return "R10";
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [64:0] e64, e32;
    string       t64, t32;

    task automatic compare_now();
        check(t64, "rd64",  rd64,         e64[63:0]);
        check(t64, "ill64", 64'(ill64),   64'(e64[64]));
        check(t32, "rd32",  64'(rd32),    e32[63:0]);
        check(t32, "ill32", 64'(ill32),   64'(e32[64]));
    endtask

    task automatic drive(logic [4:0] o, logic [63:0] x, logic [63:0] y);
        op = o; a = x; b = y;
        e64 = model(64, o, x, y);
        e32 = model(32, o, x, y);
        t64 = tag_of(o, 1'b0);
        t32 = tag_of(o, 1'b1);
    endtask

    logic [63:0] seed = 64'h9E3779B97F4A7C15;
    function automatic logic [63:0] nxt(logic [63:0] s);
        logic [63:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    bit done = 0;

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] pa [6];
        logic [63:0] pb [6];
        rst = 1'b1;
        op = 5'd11; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset holds outputs at zero despite a pending operation
        check("R1", "rd64 reset",  rd64,        64'd0);
        check("R1", "ill64 reset", 64'(ill64),  64'd0);
        check("R1", "rd32 reset",  64'(rd32),   64'd0);
        check("R1", "ill32 reset", 64'(ill32),  64'd0);
        op = 5'd30;
        @(negedge clk);
        check("R1", "ill64 reset bad op", 64'(ill64), 64'd0);

        pa[0] = 64'h0123_4567_89AB_CDEF; pb[0] = 64'hFEDC_BA98_7654_3210;
        pa[1] = 64'h8081_8283_F0F1_7F7E; pb[1] = 64'h1122_3344_5566_7788;
        pa[2] = 64'hFFFF_FFFF_FFFF_FFFF; pb[2] = 64'h0000_0000_0000_0000;
        pa[3] = 64'h0000_8000_0080_0000; pb[3] = 64'hA5A5_5A5A_C3C3_3C3C;
        pa[4] = 64'd0;                  pb[4] = 64'd0;
        pa[5] = 64'd0;                  pb[5] = 64'd0;

        rst = 1'b0;
        drive(5'd0, pa[0], pb[0]);
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 32; c++) begin
                logic [63:0] x, y;
                if (p < 4) begin
                    x = pa[p]; y = pb[p];
                end else begin
                    seed = nxt(seed); x = seed;
                    seed = nxt(seed); y = seed;
                end
                @(negedge clk);
                compare_now();   // R1 latency: result of the previous vector
                drive(5'(c), x, y);
            end
        end
        @(negedge clk);
        compare_now();

        // R1: reset asserted while an operation is pending clears outputs
        drive(5'd19, 64'h80FF_80FF_80FF_80FF, 64'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "rd64 mid reset",  rd64,       64'd0);
        check("R1", "rd32 mid reset",  64'(rd32),  64'd0);
        rst = 1'b0;
        @(negedge clk);
        compare_now();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule